// File: doc/BRIEF.md
# Second-Chance Dirty Victim Selector

This block picks the way to replace in one set of an 8-way cache. It gives each modified line a single reprieve before eviction, so a rewrite that arrives soon afterwards can merge with the line already in the cache instead of costing a second writeback. The surrounding cache supplies the valid bit, the dirty bit and the recency rank of every way. It also reports hits and signals when a replacement is performed. The block returns the victim way and a flag saying whether the victim must be written back.

The block holds one "reprieve spent" flag per way. Victim selection is purely combinational from the inputs and these flags. The scan walks the ways from least to most recently used. A clean line, or a dirty line whose reprieve is already spent, is taken at once. A dirty line with its reprieve unspent is passed over, and its reprieve is consumed when the replacement is committed. If no line qualifies, every reprieve is consumed and the least recently used line is evicted anyway. The flags change only at a clock edge that carries the replacement strobe or the hit strobe.

Recency encoding: way `w` takes its rank from `lru_rank[3*w +: 3]`. Rank 0 is the most recently used way and rank 7 the least recently used. The eight ranks form a permutation. The recency stack itself lives outside this block.

Top module: `ssc_victim_sel`

## Requirements
- R1: After reset every reprieve flag is clear. With all ways valid and dirty, the victim is the way of rank 7 with `victim_wb` = 1, and the flags stay clear while no strobe is given.
- R2: If any way is invalid, the victim is the lowest-numbered invalid way, `victim_wb` is 0, and no other way's flag is set by that replacement.
- R3: If all ways are valid, the victim is the way of highest rank (scanning rank 7 down to rank 0) that is either clean or dirty with its flag set.
- R4: On a committed replacement, every dirty way with a clear flag whose rank is above the victim's rank has its flag set.
- R5: `victim_wb` is 1 exactly when the chosen victim is valid and dirty. A clean or invalid victim never requests a writeback.
- R6: If all ways are valid, dirty and unspent, the victim is the way of rank 7 with `victim_wb` = 1, and the committed replacement sets the flags of all other ways.
- R7: On a committed replacement, the victim's flag is cleared, because a new line takes its place.
- R8: A clock edge with `hit_strobe` high clears the flag of `hit_way`. This takes precedence over a set caused by a replacement in the same cycle.
- R9: Without either strobe the flags hold. The victim outputs follow the inputs in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_valid | input | 8 | Valid bit per way |
| line_dirty | input | 8 | Dirty bit per way |
| lru_rank | input | 24 | Recency rank per way, 3 bits each, 7 = least recent |
| hit_strobe | input | 1 | An access hit `hit_way` this cycle |
| hit_way | input | 3 | Way that was accessed |
| repl_strobe | input | 1 | Commit the current victim choice |
| victim_way | output | 3 | Selected way to replace |
| victim_wb | output | 1 | Selected way needs a writeback |

## Verification
`victim_way` and `victim_wb` are due in the same cycle as the inputs that form them. The flag updates from either strobe first affect the outputs in the cycle after the strobe edge. The bench changes inputs on the falling edge and compares the outputs 1 ns later, before the next rising edge. Its reference model applies the strobe's flag changes only after that comparison, so every output is checked against the flag state that the RTL holds at that moment.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    parameter int unsigned SSC_WAYS = 8;

    function automatic int unsigned idx_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/ssc_rank_order.sv
module ssc_rank_order #(
    parameter int unsigned NUM_WAYS = ssc_pkg::SSC_WAYS,
    localparam int unsigned WW = ssc_pkg::idx_w(NUM_WAYS)
) (
    input  logic [NUM_WAYS*WW-1:0] rank_vec,
    output logic [NUM_WAYS*WW-1:0] way_at_rank
);
    // invert the way->rank permutation into rank->way
    always_comb begin
        way_at_rank = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            way_at_rank[int'(rank_vec[w*WW +: WW])*WW +: WW] = WW'(w);
        end
    end
endmodule

// File: rtl/ssc_pick.sv
module ssc_pick #(
    parameter int unsigned NUM_WAYS = ssc_pkg::SSC_WAYS,
    localparam int unsigned WW = ssc_pkg::idx_w(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0]    valid,
    input  logic [NUM_WAYS-1:0]    dirty,
    input  logic [NUM_WAYS-1:0]    spent,
    input  logic [NUM_WAYS*WW-1:0] rank_vec,
    input  logic [NUM_WAYS*WW-1:0] way_at_rank,
    output logic [WW-1:0]          victim,
    output logic                   wb,
    output logic [NUM_WAYS-1:0]    skip
);
    logic [NUM_WAYS-1:0] eligible;
    logic                has_inv;
    logic [WW-1:0]       inv_way;
    logic                found;
    int                  vrank;
    logic [WW-1:0]       scan_way;

    assign eligible = ~dirty | spent;

    always_comb begin
        has_inv = 1'b0;
        inv_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                has_inv = 1'b1;
                inv_way = WW'(w);
            end
        end
    end

    // highest eligible rank wins (last assignment in ascending scan)
    always_comb begin
        found = 1'b0;
        vrank = NUM_WAYS - 1;
        for (int r = 0; r < NUM_WAYS; r++) begin
            if (eligible[way_at_rank[r*WW +: WW]]) begin
                found = 1'b1;
                vrank = r;
            end
        end
        scan_way = way_at_rank[vrank*WW +: WW];
    end

    always_comb begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            skip[w] = !has_inv && dirty[w] && !spent[w] &&
                      (!found || (int'(rank_vec[w*WW +: WW]) > vrank));
        end
    end

    assign victim = has_inv ? inv_way : scan_way;
    assign wb     = valid[victim] && dirty[victim];
endmodule

// File: rtl/ssc_flags.sv
module ssc_flags #(
    parameter int unsigned NUM_WAYS = ssc_pkg::SSC_WAYS,
    localparam int unsigned WW = ssc_pkg::idx_w(NUM_WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                repl,
    input  logic [WW-1:0]       victim,
    input  logic [NUM_WAYS-1:0] skip,
    input  logic                hit,
    input  logic [WW-1:0]       hit_way,
    output logic [NUM_WAYS-1:0] spent_q
);
    logic [NUM_WAYS-1:0] spent_d;
    logic [NUM_WAYS-1:0] clr_victim;
    logic [NUM_WAYS-1:0] clr_hit;

    assign clr_victim = repl ? (NUM_WAYS'(1) << victim) : '0;
    assign clr_hit    = hit  ? (NUM_WAYS'(1) << hit_way) : '0;

    always_comb begin
        spent_d = spent_q;
        if (repl) spent_d = (spent_d | skip) & ~clr_victim;
        spent_d = spent_d & ~clr_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) spent_q <= '0;
        else        spent_q <= spent_d;
    end
endmodule

// File: rtl/ssc_victim_sel.sv
module ssc_victim_sel #(
    parameter int unsigned NUM_WAYS = ssc_pkg::SSC_WAYS,
    localparam int unsigned WW = ssc_pkg::idx_w(NUM_WAYS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_WAYS-1:0]    line_valid,
    input  logic [NUM_WAYS-1:0]    line_dirty,
    input  logic [NUM_WAYS*WW-1:0] lru_rank,
    input  logic                   hit_strobe,
    input  logic [WW-1:0]          hit_way,
    input  logic                   repl_strobe,
    output logic [WW-1:0]          victim_way,
    output logic                   victim_wb
);
    logic [NUM_WAYS*WW-1:0] way_at_rank;
    logic [NUM_WAYS-1:0]    spent_q;
    logic [NUM_WAYS-1:0]    skip;

    ssc_rank_order #(.NUM_WAYS(NUM_WAYS)) u_order (
        .rank_vec   (lru_rank),
        .way_at_rank(way_at_rank)
    );

    ssc_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
        .valid      (line_valid),
        .dirty      (line_dirty),
        .spent      (spent_q),
        .rank_vec   (lru_rank),
        .way_at_rank(way_at_rank),
        .victim     (victim_way),
        .wb         (victim_wb),
        .skip       (skip)
    );

    ssc_flags #(.NUM_WAYS(NUM_WAYS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .repl   (repl_strobe),
        .victim (victim_way),
        .skip   (skip),
        .hit    (hit_strobe),
        .hit_way(hit_way),
        .spent_q(spent_q)
    );
endmodule

// File: rtl/ssc_victim_sel_chk.sv
module ssc_victim_sel_chk #(
    parameter int unsigned NUM_WAYS = ssc_pkg::SSC_WAYS,
    localparam int unsigned WW = ssc_pkg::idx_w(NUM_WAYS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_WAYS-1:0] line_valid,
    input logic [NUM_WAYS-1:0] line_dirty,
    input logic                hit_strobe,
    input logic [WW-1:0]       hit_way,
    input logic                repl_strobe,
    input logic [WW-1:0]       victim_way,
    input logic                victim_wb,
    input logic [NUM_WAYS-1:0] spent_q
);
    // R2
    inv_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&line_valid)) |-> !line_valid[victim_way]);

    // R5
    inv_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&line_valid)) |-> !victim_wb);

    // R6
    fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&line_valid) && victim_wb && !spent_q[victim_way])
            |-> (&(line_dirty & ~spent_q)));

    // R7
    victim_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        repl_strobe |=> !spent_q[$past(victim_way)]);

    // R8
    hit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_strobe |=> !spent_q[$past(hit_way)]);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_strobe && !repl_strobe) |=> $stable(spent_q));

    // R4
    only_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (repl_strobe && !hit_strobe) |=>
            ($countones($past(spent_q) & ~spent_q &
                        ~(NUM_WAYS'(1) << $past(victim_way))) == 0));
endmodule

bind ssc_victim_sel ssc_victim_sel_chk #(.NUM_WAYS(NUM_WAYS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_valid (line_valid),
    .line_dirty (line_dirty),
    .hit_strobe (hit_strobe),
    .hit_way    (hit_way),
    .repl_strobe(repl_strobe),
    .victim_way (victim_way),
    .victim_wb  (victim_wb),
    .spent_q    (spent_q)
);

// File: tb/test_ssc_victim_sel.sv
`timescale 1ns/1ps
module test_ssc_victim_sel;
    localparam int N  = 8;
    localparam int WW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    line_valid = '1;
    logic [N-1:0]    line_dirty = '1;
    logic [N*WW-1:0] lru_rank = '0;
    logic            hit_strobe = 1'b0;
    logic [WW-1:0]   hit_way = '0;
    logic            repl_strobe = 1'b0;
    logic [WW-1:0]   victim_way;
    logic            victim_wb;

    int checks = 0;
    int bad = 0;
    bit m_spent[N];
    int rk[N];

    always #2 clk = ~clk;

    ssc_victim_sel i_ssc_victim_sel (
        .clk(clk), .rst_n(rst_n),
        .line_valid(line_valid), .line_dirty(line_dirty), .lru_rank(lru_rank),
        .hit_strobe(hit_strobe), .hit_way(hit_way), .repl_strobe(repl_strobe),
        .victim_way(victim_way), .victim_wb(victim_wb)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; hit_strobe = 1'b0; repl_strobe = 1'b0;
        for (int w = 0; w < N; w++) m_spent[w] = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic identity_ranks();
        for (int w = 0; w < N; w++) rk[w] = w;
    endtask

    task automatic shuffle_ranks();
        identity_ranks();
        for (int i = N - 1; i > 0; i--) begin
            int j;
            int t;
            j = $urandom_range(i, 0);
            t = rk[i]; rk[i] = rk[j]; rk[j] = t;
        end
    endtask

    task automatic step(input logic [N-1:0] v, input logic [N-1:0] d,
                        input logic hs, input int hw, input logic rs,
                        input string tag);
        int ev;
        bit ewb;
        bit skip[N];
        @(negedge clk);
        line_valid = v; line_dirty = d;
        hit_strobe = hs; hit_way = WW'(hw); repl_strobe = rs;
        for (int w = 0; w < N; w++) lru_rank[w*WW +: WW] = WW'(rk[w]);
        #1;
        ev = -1;
        for (int w = 0; w < N; w++) skip[w] = 1'b0;
        for (int w = 0; w < N; w++) if (ev < 0 && !v[w]) ev = w;
        if (ev < 0) begin
            for (int r = N - 1; r >= 0; r--) begin
                int wr;
                wr = 0;
                for (int w = 0; w < N; w++) if (rk[w] == r) wr = w;
                if (ev < 0) begin
                    if (!d[wr] || m_spent[wr]) ev = wr;
                    else skip[wr] = 1'b1;
                end
            end
            if (ev < 0) for (int w = 0; w < N; w++) if (rk[w] == N - 1) ev = w;
        end
        ewb = v[ev] && d[ev];
        check({tag, " victim_way"}, int'(victim_way), ev);
        check({tag, " victim_wb"}, int'(victim_wb), int'(ewb));
        if (rs) begin
            for (int w = 0; w < N; w++) if (skip[w]) m_spent[w] = 1'b1;
            m_spent[ev] = 1'b0;
        end
        if (hs) m_spent[hw] = 1'b0;
    endtask

    initial begin
        #800000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        identity_ranks();
        do_reset();
        // R1: clear flags after reset, all dirty -> rank 7 way with writeback
        step(8'hFF, 8'hFF, 0, 0, 0, "R1 reset");
        step(8'hFF, 8'hFF, 0, 0, 0, "R1 hold");
        // R2: invalid ways 3 and 5 -> way 3, no writeback
        step(8'hD7, 8'hFF, 0, 0, 1, "R2 invalid");
        // R3 R4: dirty 4..7 skipped, clean way 3 taken
        step(8'hFF, 8'hF0, 0, 0, 1, "R3 clean after skip");
        // R5 R7: way 7 now spent -> evicted with writeback
        step(8'hFF, 8'hF0, 0, 0, 1, "R5 spent dirty");
        // R8: hit clears way 6
        step(8'hFF, 8'hF0, 1, 6, 0, "R8 hit");
        step(8'hFF, 8'hF0, 0, 0, 1, "R8 after hit");
        // R9: no strobe, flags hold
        step(8'hFF, 8'hF0, 0, 0, 0, "R9 hold");
        step(8'hFF, 8'hF0, 0, 0, 0, "R9 hold again");
        // R6: all dirty and unspent -> fallback
        do_reset();
        step(8'hFF, 8'hFF, 0, 0, 1, "R6 fallback");
        step(8'hFF, 8'hFF, 0, 0, 0, "R6 after fallback");
        rk[0] = 7; rk[7] = 0;
        step(8'hFF, 8'hFF, 0, 0, 1, "R6 spent way");
        // R8: hit and replacement in the same cycle on the same way
        step(8'hFF, 8'hFF, 1, 6, 1, "R8 hit with repl");
        step(8'hFF, 8'hFF, 0, 0, 0, "R8 hit wins");
        // random mixes over R2 R3 R4 R5 R7 R8 R9
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] v;
            logic [N-1:0] d;
            shuffle_ranks();
            v = ($urandom_range(3, 0) == 0) ? N'($urandom) : '1;
            d = N'($urandom) | N'($urandom);
            step(v, d, ($urandom_range(3, 0) == 0), $urandom_range(N - 1, 0),
                 ($urandom_range(1, 0) == 1), "R3 random");
        end
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule